// File: doc/BRIEF.md
# Convolution Tap Sharing Analyzer

This block sits in the configuration path of a 3x3 convolution engine. When it receives a start pulse, it captures a nine-coefficient mask and finds which tap positions hold the same coefficient. It produces three results: the number of distinct coefficient values, a group index for every position, and an ordered list of the distinct values. From these, the datapath can feed one shared multiplier per distinct value instead of one per tap.

The block also reports how many pixel windows an 18-multiplier pool can handle in one cycle for the captured mask. That figure is the pool size divided by the distinct count, rounded down. A mask with fewer distinct values lets more windows be processed at once.

The analysis is serial. It compares one tap per cycle against the values found so far, and a done flag marks when the results are settled.

Top module: `tap_share_analyzer`

## Requirements
- R1: After reset, done_o and busy_o are low, and uniq_cnt_o, win_par_o, group_o and uniq_val_o are all zero.
- R2: Suppose start_i is high at a rising edge while busy_o is low; this is an accepted start. busy_o is high from that edge until the tenth following edge. At that tenth edge busy_o falls and done_o rises.
- R3: uniq_cnt_o gives the number of distinct 8-bit two's complement tap values, from 1 to 9. Equality is exact bit equality, so 8'h01 and 8'hFF are different values.
- R4: Tap k is read from mask_i[8k+7:8k], and its group is placed on group_o[4k+3:4k]. Groups are numbered in order of first appearance in raster order 0..8. Tap 0 always has group 0, and equal taps share a group.
- R5: uniq_val_o[8g+7:8g] holds the coefficient of group g. Slots g >= uniq_cnt_o read zero.
- R6: win_par_o equals floor(18 / uniq_cnt_o). This gives 18, 9, 6, 4, 3, 3, 2, 2, 2 for counts 1 to 9.
- R7: A start pulse while busy_o is high is ignored. Done timing and results follow the accepted start and its mask.
- R8: While done_o is high and no start arrives, all results stay constant, whatever mask_i does.
- R9: An accepted start while done_o is high clears done_o on that edge. It then produces results for the newly captured mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture mask and begin analysis |
| mask_i | input | 72 | Nine 8-bit signed taps, tap k at bits 8k+7:8k |
| busy_o | output | 1 | Analysis in progress |
| done_o | output | 1 | Results valid |
| uniq_cnt_o | output | 4 | Number of distinct tap values |
| group_o | output | 36 | Group index per tap, 4 bits each |
| uniq_val_o | output | 72 | Distinct values in group order, 8 bits each |
| win_par_o | output | 5 | Windows per cycle for an 18-multiplier pool |

## Verification
The assertions assume that start_i and mask_i are known at every sampled edge. They also assume a mask is only meaningful at the edge that accepts a start. They make no claim about mask_i at other times, and the latency check counts from accepted starts only.

The bench drives every input on the falling edge. It holds start_i for exactly one cycle per pulse, except for the deliberate pulse inside a running analysis. It changes mask_i freely between starts, which exercises the rule that only the captured mask matters.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} scan_st_e;
endpackage

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl #(
  parameter int TAPS  = 9,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  import tap_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

  scan_st_e         st_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o = (st_q != ST_IDLE);
  assign load_o = start_i && !busy_o;
  assign step_o = (st_q == ST_SCAN);
  assign fin_o  = (st_q == ST_FIN);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SCAN;
          idx_q <= '0;
        end
        ST_SCAN: begin
          if (idx_q == LAST) st_q <= ST_FIN;
          else               idx_q <= idx_q + 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tap_match.sv
module tap_match #(
  parameter int TAPS  = 9,
  parameter int TAP_W = 8,
  parameter int GRP_W = $clog2(TAPS),
  parameter int CNT_W = $clog2(TAPS + 1)
) (
  input  logic [TAP_W-1:0]            tap_i,
  input  logic [TAPS-1:0][TAP_W-1:0]  vals_i,
  input  logic [CNT_W-1:0]            cnt_i,
  output logic                        hit_o,
  output logic [GRP_W-1:0]            hit_idx_o
);
  logic [TAPS-1:0] eq;

  for (genvar s = 0; s < TAPS; s++) begin : g_cmp
    assign eq[s] = (CNT_W'(s) < cnt_i) && (vals_i[s] == tap_i);
  end

  assign hit_o = |eq;

  // lowest matching slot wins; stored values are distinct so at most one hits
  always_comb begin
    hit_idx_o = '0;
    for (int s = TAPS - 1; s >= 0; s--) begin
      if (eq[s]) hit_idx_o = GRP_W'(s);
    end
  end
endmodule

// File: rtl/tap_par_calc.sv
module tap_par_calc #(
  parameter int TAPS  = 9,
  parameter int MULTS = 18,
  parameter int CNT_W = $clog2(TAPS + 1),
  parameter int WIN_W = $clog2(MULTS + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [WIN_W-1:0] win_o
);
  always_comb begin
    int q;
    q = (cnt_i == '0) ? 0 : (MULTS / int'(cnt_i));
    win_o = WIN_W'(q);
  end
endmodule

// File: rtl/tap_share_analyzer.sv
module tap_share_analyzer #(
  parameter int TAPS  = 9,
  parameter int TAP_W = 8,
  parameter int MULTS = 18,
  parameter int GRP_W = $clog2(TAPS),
  parameter int CNT_W = $clog2(TAPS + 1),
  parameter int WIN_W = $clog2(MULTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [TAPS*TAP_W-1:0]   mask_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        uniq_cnt_o,
  output logic [TAPS*GRP_W-1:0]   group_o,
  output logic [TAPS*TAP_W-1:0]   uniq_val_o,
  output logic [WIN_W-1:0]        win_par_o
);
  logic                        load, step, fin;
  logic [GRP_W-1:0]            idx;
  logic [TAPS-1:0][TAP_W-1:0]  mask_q, vals_q;
  logic [TAPS-1:0][GRP_W-1:0]  grp_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [WIN_W-1:0]            win_q, win_c;
  logic                        done_q;
  logic                        hit;
  logic [GRP_W-1:0]            hit_idx;
  logic [TAP_W-1:0]            cur_tap;

  tap_scan_ctrl #(.TAPS(TAPS), .IDX_W(GRP_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o),
    .idx_o  (idx)
  );

  assign cur_tap = mask_q[idx];

  tap_match #(.TAPS(TAPS), .TAP_W(TAP_W), .GRP_W(GRP_W), .CNT_W(CNT_W)) u_match (
    .tap_i    (cur_tap),
    .vals_i   (vals_q),
    .cnt_i    (cnt_q),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  tap_par_calc #(.TAPS(TAPS), .MULTS(MULTS), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_par (
    .cnt_i(cnt_q),
    .win_o(win_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      vals_q <= '0;
      grp_q  <= '0;
      cnt_q  <= '0;
      win_q  <= '0;
      done_q <= 1'b0;
    end else if (load) begin
      mask_q <= mask_i;
      vals_q <= '0;
      grp_q  <= '0;
      cnt_q  <= '0;
      win_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      if (hit) begin
        grp_q[idx] <= hit_idx;
      end else begin
        grp_q[idx]               <= GRP_W'(cnt_q);
        vals_q[GRP_W'(cnt_q)]    <= cur_tap;
        cnt_q                    <= cnt_q + 1'b1;
      end
    end else if (fin) begin
      win_q  <= win_c;
      done_q <= 1'b1;
    end
  end

  assign done_o     = done_q;
  assign uniq_cnt_o = cnt_q;
  assign group_o    = grp_q;
  assign uniq_val_o = vals_q;
  assign win_par_o  = win_q;
endmodule

// File: rtl/tap_share_analyzer_chk.sv
module tap_share_analyzer_chk #(
  parameter int TAPS  = 9,
  parameter int TAP_W = 8,
  parameter int MULTS = 18,
  parameter int GRP_W = $clog2(TAPS),
  parameter int CNT_W = $clog2(TAPS + 1),
  parameter int WIN_W = $clog2(MULTS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  busy_o,
  input logic                  done_o,
  input logic [CNT_W-1:0]      uniq_cnt_o,
  input logic [TAPS*GRP_W-1:0] group_o,
  input logic [TAPS*TAP_W-1:0] uniq_val_o,
  input logic [WIN_W-1:0]      win_par_o
);
  localparam int LAT = TAPS + 1;
  logic [5:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= 6'd63;
    else if (start_i && !busy_o) since_q <= 6'd1;
    else if (since_q != 6'd63)  since_q <= since_q + 6'd1;
  end

  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (since_q == 6'(LAT + 1)));

  a_r2_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (uniq_cnt_o >= 1 && int'(uniq_cnt_o) <= TAPS));

  a_r4_first_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (group_o[GRP_W-1:0] == '0));

  for (genvar k = 0; k < TAPS; k++) begin : g_slot
    a_r4_group_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (CNT_W'(group_o[k*GRP_W +: GRP_W]) < uniq_cnt_o));
    a_r5_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && CNT_W'(k) >= uniq_cnt_o) |-> (uniq_val_o[k*TAP_W +: TAP_W] == '0));
  end

  a_r6_win_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((int'(win_par_o) * int'(uniq_cnt_o) <= MULTS) &&
                ((int'(win_par_o) + 1) * int'(uniq_cnt_o) > MULTS)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(group_o) && $stable(uniq_val_o) &&
                              $stable(uniq_cnt_o) && $stable(win_par_o) && done_o));
endmodule

bind tap_share_analyzer tap_share_analyzer_chk #(
  .TAPS(TAPS), .TAP_W(TAP_W), .MULTS(MULTS),
  .GRP_W(GRP_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .uniq_cnt_o(uniq_cnt_o),
  .group_o   (group_o),
  .uniq_val_o(uniq_val_o),
  .win_par_o (win_par_o)
);

// File: tb/tap_share_analyzer_test.sv
module tap_share_analyzer_test;
  localparam int NV = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [71:0] mask_i = '0;
  logic        busy_o, done_o;
  logic [3:0]  uniq_cnt_o;
  logic [35:0] group_o;
  logic [71:0] uniq_val_o;
  logic [4:0]  win_par_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  tap_share_analyzer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mask_i(mask_i),
    .busy_o(busy_o), .done_o(done_o), .uniq_cnt_o(uniq_cnt_o),
    .group_o(group_o), .uniq_val_o(uniq_val_o), .win_par_o(win_par_o)
  );

  localparam logic [7:0] MASKS [NV][9] = '{
    '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
    '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'd8, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    '{8'hFF, 8'hFF, 8'hFF, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1},
    '{8'hFF, 8'hFE, 8'hFF, 8'd0, 8'd0, 8'd0, 8'd1, 8'd2, 8'd1},
    '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8},
    '{8'd1, 8'd2, 8'd3, 8'd4, 8'd1, 8'd2, 8'd3, 8'd4, 8'd1},
    '{8'd1, 8'hFF, 8'd1, 8'hFF, 8'd1, 8'hFF, 8'd1, 8'hFF, 8'd1},
    '{8'd5, 8'd5, 8'd5, 8'hFD, 8'd7, 8'd9, 8'd11, 8'd13, 8'd5},
    '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd0, 8'd0},
    '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd7}
  };
  localparam int GRPS [NV][9] = '{
    '{0, 0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 1, 0, 0, 0, 0},
    '{0, 0, 0, 1, 1, 1, 2, 2, 2},
    '{0, 1, 0, 2, 2, 2, 3, 4, 3},
    '{0, 1, 2, 3, 4, 5, 6, 7, 8},
    '{0, 1, 2, 3, 0, 1, 2, 3, 0},
    '{0, 1, 0, 1, 0, 1, 0, 1, 0},
    '{0, 0, 0, 1, 2, 3, 4, 5, 0},
    '{0, 1, 2, 3, 4, 5, 6, 0, 0},
    '{0, 1, 2, 3, 4, 5, 6, 7, 7}
  };
  localparam int CNTS [NV] = '{1, 2, 3, 5, 9, 4, 2, 6, 7, 8};
  localparam int WINS [NV] = '{18, 9, 6, 3, 2, 4, 9, 3, 2, 2};

  function automatic logic [71:0] pack_mask(int n);
    logic [71:0] m;
    for (int k = 0; k < 9; k++) m[k*8 +: 8] = MASKS[n][k];
    return m;
  endfunction

  function automatic logic [35:0] pack_grp(int n);
    logic [35:0] g;
    for (int k = 0; k < 9; k++) g[k*4 +: 4] = 4'(GRPS[n][k]);
    return g;
  endfunction

  // value of group g is the tap at the first position carrying that group
  function automatic logic [71:0] exp_vals(int n);
    logic [71:0] v;
    v = '0;
    for (int k = 8; k >= 0; k--) v[GRPS[n][k]*8 +: 8] = MASKS[n][k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [71:0] m);
    @(negedge clk_i);
    mask_i  = m;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic check_results(input int n, input string tag);
    chk(uniq_cnt_o == 4'(CNTS[n]), {tag, " R3 count"}, 72'(uniq_cnt_o), 72'(CNTS[n]));
    chk(group_o == pack_grp(n), {tag, " R4 groups"}, 72'(group_o), 72'(pack_grp(n)));
    chk(uniq_val_o == exp_vals(n), {tag, " R5 values"}, uniq_val_o, exp_vals(n));
    chk(win_par_o == 5'(WINS[n]), {tag, " R6 windows"}, 72'(win_par_o), 72'(WINS[n]));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && uniq_cnt_o == 0 && win_par_o == 0 && group_o == '0 && uniq_val_o == '0,
        "R1 reset state", {busy_o, done_o, 70'(uniq_cnt_o)}, '0);
    rst_ni = 1'b1;

    // table walk
    for (int n = 0; n < NV; n++) begin
      launch(pack_mask(n));
      chk(busy_o && !done_o, "R2 busy after start", {busy_o, done_o}, 72'b10);
      repeat (8) @(negedge clk_i);
      mask_i = ~mask_i;  // captured mask must be used
      @(negedge clk_i);
      chk(!done_o && busy_o, "R2 done not early", {busy_o, done_o}, 72'b10);
      @(negedge clk_i);
      chk(done_o && !busy_o, "R2 done at tenth edge", {busy_o, done_o}, 72'b01);
      check_results(n, $sformatf("vec%0d", n));
    end

    // R8: hold with no start while the mask input moves
    mask_i = pack_mask(4);
    repeat (5) @(negedge clk_i);
    chk(done_o, "R8 done held", 72'(done_o), 72'd1);
    check_results(NV - 1, "R8 hold");

    // R7: second start during analysis is ignored
    launch(pack_mask(3));
    repeat (3) @(negedge clk_i);
    mask_i  = pack_mask(0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(!done_o, "R7 done not early", 72'(done_o), 72'd0);
    @(negedge clk_i);
    chk(done_o, "R7 done on original schedule", 72'(done_o), 72'd1);
    check_results(3, "R7 ignored start");

    // R9: restart from done clears done and gives new results
    @(negedge clk_i);
    mask_i  = pack_mask(6);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && busy_o, "R9 done cleared by restart", {busy_o, done_o}, 72'b10);
    repeat (10) @(negedge clk_i);
    chk(done_o, "R9 done after restart", 72'(done_o), 72'd1);
    check_results(6, "R9 restart");

    // R1: asynchronous reset mid-analysis returns to reset state
    launch(pack_mask(4));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !done_o && uniq_cnt_o == 0 && group_o == '0 && uniq_val_o == '0 && win_par_o == 0,
        "R1 reset mid scan", {busy_o, done_o, 70'(uniq_cnt_o)}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule